// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a clock-synchronous model of the command logic inside a byte-wide NOR flash device. The host presents already-decoded bus cycles: a one-cycle read strobe or write strobe with a 19-bit byte address and, for writes, an 8-bit data byte. The controller interprets the written bytes as commands. It runs two-cycle sequences for sector erase and byte program, plus a single-cycle return to read mode and an identification mode. It keeps a small internal byte array that stands in for the flash cells.

A started erase or program holds the controller busy for a parameterised number of clock cycles. During that time, reads return a completion status byte instead of array contents, and writes are dropped. A single write-protect input blocks the array-changing commands and leaves the harmless ones working. Read data is registered and appears on `rdata` one cycle after the read strobe. `rdata` holds its value between reads.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: With `rst` high, `rdata` clears to 00h and the controller enters read mode. Every array byte becomes FFh, the erased value.
- R2: In read mode, a read strobe returns the array byte at the address on `rdata` after the next clock edge. Address bits at and above ARRAY_AW are ignored, so the array aliases across the bus range.
- R3: Writing 10h arms a program. The next write stores the bitwise AND of the old byte and the written data at that write's address. The exception is a written FFh, which cancels the program.
- R4: Writing 20h arms an erase. A following write of D0h sets every byte of the 256-byte sector selected by address bits [ARRAY_AW-1:8] to FFh. Address bits [7:0] of that write are ignored, and other sectors keep their contents.
- R5: Writing FFh to an armed controller cancels the operation. The array is left unchanged, no busy period starts, and read mode resumes. An armed erase that receives any byte other than D0h is likewise abandoned.
- R6: Writing 90h enters identification mode. In this mode a read at bus address 0 returns BFh, at address 1 returns 04h, and at any other address returns 00h. Writing FFh returns to read mode. Writing 20h or 10h leaves identification mode and arms that command.
- R7: While `protect` is high, 20h and 10h are ignored, and an execute write for an armed erase or program is rejected. A rejected execute write starts nothing and returns to read mode. 90h and FFh are accepted regardless of `protect`.
- R8: A program stays busy for PROG_CYCLES clock edges and an erase for ERASE_CYCLES. Reads strobed at edges 1 to N after the starting write return status. The read at edge N+1 returns array data.
- R9: The status byte is laid out as follows. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bits 5:0 are zero.
- R10: Status bit 6 is 0 on the first read of a busy period and inverts on each later read in that period.
- R11: Write strobes that arrive while busy have no effect, including one at the last busy edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| protect | input | 1 | Write-protect level; high blocks erase and program |
| addr | input | 19 | Byte address of the current cycle |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Registered read data or status byte |

## Verification
The risky coincidence is a bus access that lands on the same clock edge as the busy timer expiring. The bench issues a read exactly at the last busy edge and another at the following edge. It expects status at the first and array data at the second. It also places an identification command on the final busy edge and expects it to be dropped, so that the next read still shows array contents. Random program, erase, read and identification traffic follows, with `protect` asserted at random. Each outcome is compared against a bench-side array model and status function.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BUS_AW    = 19;
    localparam int BYTE_W    = 8;
    localparam int SECTOR_AW = 8;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BUS_AW-1:0] baddr_t;

    // command byte values
    localparam byte_t CMD_ERASE_ARM = 8'h20;
    localparam byte_t CMD_ERASE_GO  = 8'hD0;
    localparam byte_t CMD_PROG_ARM  = 8'h10;
    localparam byte_t CMD_IDENT     = 8'h90;
    localparam byte_t CMD_ABORT     = 8'hFF;

    localparam byte_t ID_MAKER = 8'hBF;
    localparam byte_t ID_PART  = 8'h04;
    localparam byte_t ERASED   = 8'hFF;

    typedef enum logic [1:0] {
        MD_READ,
        MD_ERASE_ARMED,
        MD_PROG_ARMED,
        MD_ID
    } mode_e;

    typedef enum logic [1:0] {
        JOB_NONE,
        JOB_PROG,
        JOB_ERASE
    } job_kind_e;

    // what the read path remembers about the running job
    typedef struct packed {
        job_kind_e kind;
        logic      bit7;
    } busy_info_t;

    function automatic byte_t status_byte(busy_info_t info, logic tog);
        byte_t s;
        s    = '0;
        s[7] = (info.kind == JOB_PROG) ? ~info.bit7 : 1'b0;
        s[6] = tog;
        return s;
    endfunction

    function automatic byte_t id_byte(baddr_t a);
        if (a == baddr_t'(0)) return ID_MAKER;
        if (a == baddr_t'(1)) return ID_PART;
        return '0;
    endfunction

endpackage

// File: rtl/fcc_cmd_fsm.sv
module fcc_cmd_fsm
    import flash_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      protect,
    input  logic      busy,
    input  byte_t     wdata,
    output mode_e     mode_q,
    output job_kind_e start_kind
);

    mode_e mode_d;

    always_comb begin
        mode_d     = mode_q;
        start_kind = JOB_NONE;
        if (wr_en && !busy) begin
            unique case (mode_q)
                MD_READ, MD_ID: begin
                    case (wdata)
                        CMD_ERASE_ARM: if (!protect) mode_d = MD_ERASE_ARMED;
                        CMD_PROG_ARM:  if (!protect) mode_d = MD_PROG_ARMED;
                        CMD_IDENT:     mode_d = MD_ID;
                        CMD_ABORT:     mode_d = MD_READ;
                        default:       mode_d = mode_q;
                    endcase
                end
                MD_ERASE_ARMED: begin
                    mode_d = MD_READ;
                    if (wdata == CMD_ERASE_GO && !protect) start_kind = JOB_ERASE;
                end
                MD_PROG_ARMED: begin
                    mode_d = MD_READ;
                    if (wdata != CMD_ABORT && !protect) start_kind = JOB_PROG;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MD_READ;
        else     mode_q <= mode_d;
    end

endmodule

// File: rtl/fcc_busy_timer.sv
module fcc_busy_timer
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYCLES  = 35,
    parameter int ERASE_CYCLES = 4000
) (
    input  logic      clk,
    input  logic      rst,
    input  job_kind_e start_kind,
    output logic      busy
);

    localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW      = $clog2(LONGEST + 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)                          remain_q <= '0;
        else if (start_kind == JOB_PROG)  remain_q <= CW'(PROG_CYCLES);
        else if (start_kind == JOB_ERASE) remain_q <= CW'(ERASE_CYCLES);
        else if (remain_q != '0)          remain_q <= remain_q - 1'b1;
    end

    assign busy = (remain_q != '0);

endmodule

// File: rtl/fcc_array.sv
module fcc_array
    import flash_cmd_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  job_kind_e       start_kind,
    input  logic [AW-1:0]   job_addr,
    input  byte_t           job_data,
    input  logic [AW-1:0]   rd_addr,
    output byte_t           rd_byte
);

    localparam int SEC_W     = AW - SECTOR_AW;
    localparam int NSEC      = 1 << SEC_W;
    localparam int SEC_DEPTH = 1 << SECTOR_AW;

    logic [SEC_W-1:0] job_sec;
    byte_t            sec_q [NSEC];

    assign job_sec = job_addr[AW-1:SECTOR_AW];

    for (genvar s = 0; s < NSEC; s++) begin : g_sector
        byte_t cells [SEC_DEPTH];
        logic  hit;

        assign hit = (job_sec == SEC_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < SEC_DEPTH; i++) cells[i] <= ERASED;
            end else if (hit && start_kind == JOB_ERASE) begin
                for (int i = 0; i < SEC_DEPTH; i++) cells[i] <= ERASED;
            end else if (hit && start_kind == JOB_PROG) begin
                cells[job_addr[SECTOR_AW-1:0]] <= cells[job_addr[SECTOR_AW-1:0]] & job_data;
            end
        end

        assign sec_q[s] = cells[rd_addr[SECTOR_AW-1:0]];
    end

    assign rd_byte = sec_q[rd_addr[AW-1:SECTOR_AW]];

endmodule

// File: rtl/fcc_read_path.sv
module fcc_read_path
    import flash_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_en,
    input  baddr_t    addr,
    input  mode_e     mode,
    input  logic      busy,
    input  job_kind_e start_kind,
    input  logic      start_bit7,
    input  byte_t     arr_byte,
    output byte_t     rdata
);

    busy_info_t info_q;
    logic       tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q <= '{kind: JOB_NONE, bit7: 1'b0};
            tog_q  <= 1'b0;
            rdata  <= '0;
        end else begin
            if (start_kind != JOB_NONE) begin
                info_q <= '{kind: start_kind, bit7: start_bit7};
                tog_q  <= 1'b0;
            end else if (rd_en && busy) begin
                tog_q  <= ~tog_q;
            end
            if (rd_en) begin
                if (busy)               rdata <= status_byte(info_q, tog_q);
                else if (mode == MD_ID) rdata <= id_byte(addr);
                else                    rdata <= arr_byte;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ARRAY_AW     = 10,
    parameter int PROG_CYCLES  = 35,
    parameter int ERASE_CYCLES = 4000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic        protect,
    input  logic [18:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata
);

    mode_e     mode_q;
    job_kind_e start_kind;
    logic      busy;
    byte_t     arr_byte;

    fcc_cmd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .protect    (protect),
        .busy       (busy),
        .wdata      (wdata),
        .mode_q     (mode_q),
        .start_kind (start_kind)
    );

    fcc_busy_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start_kind (start_kind),
        .busy       (busy)
    );

    fcc_array #(
        .AW (ARRAY_AW)
    ) u_array (
        .clk        (clk),
        .rst        (rst),
        .start_kind (start_kind),
        .job_addr   (addr[ARRAY_AW-1:0]),
        .job_data   (wdata),
        .rd_addr    (addr[ARRAY_AW-1:0]),
        .rd_byte    (arr_byte)
    );

    fcc_read_path u_rpath (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .addr       (addr),
        .mode       (mode_q),
        .busy       (busy),
        .start_kind (start_kind),
        .start_bit7 (wdata[7]),
        .arr_byte   (arr_byte),
        .rdata      (rdata)
    );

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
    import flash_cmd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        wr_en,
    input logic        protect,
    input logic [18:0] addr,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input mode_e       mode,
    input logic        busy
);

    // a busy period only begins after an unprotected write
    assert_start_unprotected_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wr_en) && !$past(protect)));

    // back-to-back status reads show opposite bit 6
    assert_toggle_alternates_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_en && $past(busy && rd_en)) |=> (rdata[6] != $past(rdata[6])));

    // identification read at address zero
    assert_ident_maker_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_ID && rd_en && !busy && addr == 19'd0) |=> (rdata == 8'hBF));

    // abort byte on an armed controller starts nothing
    assert_abort_cancels_R5: assert property (@(posedge clk) disable iff (rst)
        ((mode == MD_ERASE_ARMED || mode == MD_PROG_ARMED) && wr_en && !busy && wdata == 8'hFF)
        |=> (!busy && mode == MD_READ));

    // writes landing on a busy controller leave the mode alone
    assert_busy_write_dropped_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> (mode == $past(mode)));

endmodule

bind flash_cmd_ctrl fcc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .protect (protect),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .mode    (mode_q),
    .busy    (busy)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

    localparam int AW = 10;
    localparam int P  = 12;
    localparam int E  = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        protect = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [1 << AW];

    always #2 clk = ~clk;

    flash_cmd_ctrl #(
        .ARRAY_AW     (AW),
        .PROG_CYCLES  (P),
        .ERASE_CYCLES (E)
    ) dut_i (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .protect (protect),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    function automatic logic [7:0] exp_status(bit is_prog, logic [7:0] d, bit tog);
        return {(is_prog ? ~d[7] : 1'b0), tog, 6'b000000};
    endfunction

    function automatic logic [7:0] exp_id(logic [18:0] a);
        if (a == 19'd0) return 8'hBF;
        if (a == 19'd1) return 8'h04;
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [18:0] a, input logic [7:0] d, input logic prot);
        @(negedge clk);
        addr = a; wdata = d; protect = prot; wr_en = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0; protect = 1'b0;
    endtask

    task automatic read_check(input logic [18:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_program(input logic [18:0] a, input logic [7:0] d);
        bus_write(19'h7ABCD, 8'h10, 1'b0);
        bus_write(a, d, 1'b0);
        model[a[AW-1:0]] = model[a[AW-1:0]] & d;
    endtask

    task automatic do_erase(input logic [18:0] a);
        bus_write(19'h00555, 8'h20, 1'b0);
        bus_write(a, 8'hD0, 1'b0);
        for (int i = 0; i < 256; i++) model[{a[AW-1:8], i[7:0]}] = 8'hFF;
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 rdata after reset", rdata, 8'h00);
        read_check(19'h005, 8'hFF, "R1 erased array");
        read_check(19'h3FF, 8'hFF, "R1 erased array top");

        // R3/R8/R9/R10 program with full busy window
        do_program(19'h123, 8'hA5);
        read_check(19'h123, 8'h00, "R9 status bit7 of A5");
        read_check(19'h123, 8'h40, "R10 second toggle");
        for (int k = 3; k <= P; k++)
            read_check(19'h123, exp_status(1'b1, 8'hA5, bit'((k - 1) % 2)), "R8 busy window");
        read_check(19'h123, 8'hA5, "R8 data after busy");

        // R3 AND programming and R9 bit7 for a zero data bit
        do_program(19'h123, 8'h3C);
        read_check(19'h000, 8'h80, "R9 status bit7 of 3C");
        idle(P - 1);
        read_check(19'h123, 8'h24, "R3 AND of old and new");
        read_check(19'h523, 8'h24, "R2 upper address bits ignored");

        // R11 write early in busy window
        do_program(19'h200, 8'h0F);
        bus_write(19'h0, 8'h90, 1'b0);
        idle(P);
        read_check(19'h200, 8'h0F, "R11 array after busy");
        read_check(19'h000, 8'hFF, "R11 no ident mode");

        // R11 write on the final busy edge
        do_program(19'h001, 8'h11);
        idle(P - 1);
        bus_write(19'h0, 8'h90, 1'b0);
        read_check(19'h001, 8'h11, "R11 last-edge write dropped");

        // R6 identification
        bus_write(19'h0, 8'h90, 1'b0);
        read_check(19'h000, 8'hBF, "R6 maker byte");
        read_check(19'h001, 8'h04, "R6 part byte");
        read_check(19'h002, 8'h00, "R6 other address");
        read_check(19'h401, 8'h00, "R6 full address compare");
        bus_write(19'h0, 8'h20, 1'b0);
        bus_write(19'h0, 8'hFF, 1'b0);
        read_check(19'h001, 8'h11, "R6 left ident via 20h, R5 cancel");

        // R4 erase with boundary
        do_erase(19'h1AB);
        read_check(19'h000, 8'h00, "R9 erase status");
        read_check(19'h000, 8'h40, "R10 erase toggle");
        idle(E - 3);
        read_check(19'h000, 8'h00, "R8 last erase edge");
        read_check(19'h123, 8'hFF, "R4 sector erased");
        read_check(19'h200, 8'h0F, "R4 other sector kept");
        read_check(19'h001, 8'h11, "R4 sector zero kept");

        // R5 cancel and abandon
        bus_write(19'h0, 8'h10, 1'b0);
        bus_write(19'h200, 8'hFF, 1'b0);
        read_check(19'h200, 8'h0F, "R5 program cancelled");
        bus_write(19'h200, 8'h00, 1'b0);
        read_check(19'h200, 8'h0F, "R5 plain write ignored");
        bus_write(19'h0, 8'h20, 1'b0);
        bus_write(19'h0, 8'h55, 1'b0);
        bus_write(19'h200, 8'hD0, 1'b0);
        read_check(19'h200, 8'h0F, "R5 erase abandoned");

        // R7 protect
        bus_write(19'h0, 8'h10, 1'b1);
        bus_write(19'h200, 8'h00, 1'b1);
        read_check(19'h200, 8'h0F, "R7 program setup blocked");
        bus_write(19'h0, 8'h20, 1'b1);
        bus_write(19'h200, 8'hD0, 1'b1);
        read_check(19'h200, 8'h0F, "R7 erase setup blocked");
        bus_write(19'h0, 8'h90, 1'b1);
        read_check(19'h000, 8'hBF, "R7 ident accepted");
        bus_write(19'h0, 8'hFF, 1'b1);
        read_check(19'h000, 8'hFF, "R7 abort accepted");
        bus_write(19'h0, 8'h10, 1'b0);
        bus_write(19'h200, 8'h00, 1'b1);
        read_check(19'h200, 8'h0F, "R7 execute rejected");

        // random traffic
        for (int it = 0; it < 150; it++) begin
            int unsigned pick;
            logic [18:0] a;
            logic [18:0] ia;
            logic [7:0]  d;
            bit          prot;
            pick = $urandom % 4;
            a    = 19'($urandom);
            d    = 8'($urandom);
            prot = (($urandom % 4) == 0);
            case (pick)
                0: begin
                    if (d == 8'hFF) d = 8'hFE;
                    if (d == 8'h90) d = 8'h91;
                    bus_write(19'($urandom), 8'h10, prot);
                    bus_write(a, d, prot);
                    if (!prot) begin
                        model[a[AW-1:0]] = model[a[AW-1:0]] & d;
                        read_check(a, exp_status(1'b1, d, 1'b0), "R9 random program status");
                        idle(P - 1);
                    end
                    read_check(a, model[a[AW-1:0]], "R3 random program");
                end
                1: begin
                    bus_write(19'($urandom), 8'h20, prot);
                    bus_write(a, 8'hD0, prot);
                    if (!prot) begin
                        for (int i = 0; i < 256; i++) model[{a[AW-1:8], i[7:0]}] = 8'hFF;
                        read_check(a, 8'h00, "R9 random erase status");
                        idle(E - 1);
                    end
                    read_check(a, model[a[AW-1:0]], "R4 random erase");
                end
                2: read_check(a, model[a[AW-1:0]], "R2 random read");
                default: begin
                    ia = (($urandom % 2) == 0) ? 19'($urandom % 3) : a;
                    bus_write(19'($urandom), 8'h90, prot);
                    read_check(ia, exp_id(ia), "R6 random ident");
                    bus_write(19'($urandom), 8'hFF, prot);
                end
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule